// File: doc/BRIEF.md
# Fractional-Prescaler UART Baud Generator

This block produces the two timing strobes an enhanced-mode UART needs: a sample strobe at the oversampling rate and a bit strobe at the bit rate. The reference clock passes through three dividers in turn. The first is a fractional prescaler that counts in eighths. The second is a 16-bit integer divisor. The third is a programmable oversampling count. The resulting bit rate is the reference frequency divided by the prescaler, then by the divisor, then by the oversampling count. For example, a 62.5 MHz reference with a prescale of 62.5, a divisor of 1250 and 16 samples per bit gives 50 bit/s.

The prescaler is a phase accumulator that advances by 8 on every reference clock. When the accumulator reaches the programmed value, that value is subtracted and one prescaled pulse is released. The average pulse rate is therefore exact, even for non-integer settings.

A byte-wide write port loads six small registers. The prescaler only takes effect when two separate control bits are both set. Writing the low prescaler byte clears the ninth prescaler bit, so the two halves must be written low first. Any write restarts every divider from a clean phase.

Top module: `frac_baud_gen`

## Requirements
- R1: With effective prescale P (in eighths), divisor D and oversampling count N, counting cycles t from 0 in the first cycle after reset or after a write, a prescaled pulse occurs in cycle t exactly when floor(8(t+1)/P) > floor(8t/P). A sample strobe is issued on every D-th prescaled pulse.
- R2: Register addresses on `wr_addr` are: 0 divisor low byte, 1 divisor high byte, 2 prescale low byte, 3 prescale ninth bit (`wr_data[0]`), 4 oversampling code (`wr_data[3:0]`), 5 control (`wr_data[0]` enhanced mode, `wr_data[1]` prescaler enable). Each write takes effect at the clock edge where `wr_en` is high.
- R3: The programmed prescale is used only when both control bits are 1. Otherwise the prescaler divides by exactly 1 (P = 8).
- R4: A prescale value below 8 (1.000) is treated as 8. The 9-bit value counts eighths, so its maximum is 511 (63.875).
- R5: Oversampling code 0 selects 16 samples per bit, codes 1 to 3 select 4, and codes 4 to 15 select that number.
- R6: The divisor is the 16-bit value {high byte, low byte}. A value of 0 is treated as 1.
- R7: The bit strobe coincides with every N-th sample strobe. Each strobe lasts one clock, and with P = 8 and D = 1 the sample strobe is high on every clock.
- R8: In a cycle where `wr_en` is high, neither strobe is asserted. Counting restarts at t = 0 in the following cycle.
- R9: Any write to address 2 clears the ninth prescale bit.
- R10: Reset, held low on `rst_n` at a clock edge, restores: divisor 1, prescale 271 (33.875), oversampling code 0, both control bits 0. No strobe is asserted while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| sample_tick | output | 1 | Oversampling strobe, one clock wide |
| bit_tick | output | 1 | Bit-period strobe, one clock wide |

## Verification
The bench builds the block with its default parameters: a 9-bit prescaler in eighths, a 16-bit divisor and a 4-bit oversampling code. These defaults let it reach the fractional settings 1.5 and 33.875, the clamp of small prescale values, the ninth-bit clearing in both write orders, a divisor of 0 and a divisor of 258, and every class of oversampling code. Its model counts cycles since the last clean phase and derives the expected strobes with integer floor division. It does not use an accumulator, so it is independent of the RTL's structure.

// File: rtl/frac_baud_pkg.sv
// Shared widths, register addresses and reset values for the baud generator.
package frac_baud_pkg;
    localparam int FRAC_BITS = 3;           // prescale counts in 1/8 units
    localparam int PRE_W     = 9;           // prescale width in eighths
    localparam int DIV_W     = 16;          // integer divisor width
    localparam int OVS_W     = 4;           // oversampling code width
    localparam int OVS_CNT_W = OVS_W + 1;   // decoded sample count width
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam logic [PRE_W-1:0] PRE_RESET = 9'd271;  // 33.875
    localparam logic [PRE_W-1:0] PRE_ONE   = PRE_W'(1 << FRAC_BITS);

    typedef enum logic [ADDR_W-1:0] {
        REG_DIV_LO = 3'd0,
        REG_DIV_HI = 3'd1,
        REG_PRE_LO = 3'd2,
        REG_PRE_HI = 3'd3,
        REG_OVS    = 3'd4,
        REG_CTRL   = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/frac_baud_regs.sv
// Register file for the baud generator.
// It holds the divisor, prescale and oversampling settings and the two
// enable bits, and it produces the effective (clamped) division values.
// Assumes writes are single-cycle strobes.
module frac_baud_regs
    import frac_baud_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [PRE_W-1:0]     pre_eff,
    output logic [DIV_W-1:0]     div_eff,
    output logic [OVS_CNT_W-1:0] ovs_eff
);
    logic [DIV_W-1:0] div_q;
    logic [PRE_W-1:0] pre_q;
    logic [OVS_W-1:0] ovs_q;
    logic             enh_q;
    logic             pen_q;

    // Register writes; a low prescale byte write also clears the ninth bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(1);
            pre_q <= PRE_RESET;
            ovs_q <= '0;
            enh_q <= 1'b0;
            pen_q <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_DIV_LO: div_q[7:0]  <= wr_data;
                REG_DIV_HI: div_q[15:8] <= wr_data;
                REG_PRE_LO: pre_q       <= {1'b0, wr_data};
                REG_PRE_HI: pre_q[8]    <= wr_data[0];
                REG_OVS:    ovs_q       <= wr_data[OVS_W-1:0];
                REG_CTRL: begin
                    enh_q <= wr_data[0];
                    pen_q <= wr_data[1];
                end
                default: ;
            endcase
        end
    end

    // Effective prescale: bypass unless both enables are set; floor of 1.000.
    always_comb begin
        if (!(enh_q && pen_q) || pre_q < PRE_ONE) pre_eff = PRE_ONE;
        else                                      pre_eff = pre_q;
    end

    // Effective divisor: zero acts as one.
    always_comb div_eff = (div_q == '0) ? DIV_W'(1) : div_q;

    // Effective oversampling count: 0 means 16, 1..3 mean 4.
    always_comb begin
        if (ovs_q == '0)                ovs_eff = OVS_CNT_W'(16);
        else if (ovs_q < OVS_W'(4))     ovs_eff = OVS_CNT_W'(4);
        else                            ovs_eff = {1'b0, ovs_q};
    end
endmodule

// File: rtl/frac_baud_phase.sv
// Fractional prescaler built as a phase accumulator in 1/2^FRAC units.
// It adds one whole unit per clock and emits a pulse when the sum reaches
// the prescale, subtracting it. Assumes pre >= one whole unit.
module frac_baud_phase #(
    parameter int PRE_W = 9,
    parameter int FRAC  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PRE_W-1:0] pre,
    output logic             pulse
);
    localparam int SUM_W = PRE_W + 1;
    localparam logic [SUM_W-1:0] STEP = SUM_W'(1 << FRAC);

    logic [PRE_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] rem;

    // Next phase and pulse decision.
    always_comb begin
        sum   = {1'b0, acc_q} + STEP;
        pulse = (sum >= {1'b0, pre});
        rem   = pulse ? (sum - {1'b0, pre}) : sum;
    end

    // Phase register, restarted on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc_q <= '0;
        else               acc_q <= rem[PRE_W-1:0];
    end
endmodule

// File: rtl/frac_baud_count.sv
// Modulo counter on a step input. It fires on the step that completes
// `limit` steps and then wraps. Assumes limit >= 1 and that limit only
// changes together with clr.
module frac_baud_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         fire
);
    logic [W-1:0] cnt_q;

    // Terminal step detection.
    always_comb fire = step && (cnt_q == limit - W'(1));

    // Count steps, wrap on fire, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (fire)     cnt_q <= '0;
        else if (step)     cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/frac_baud_gen.sv
// Baud generator top: registers -> fractional prescaler -> divisor ->
// oversampling counter. Strobes are one clock wide. They are suppressed
// in reset and write cycles. Any write restarts all phases.
module frac_baud_gen
    import frac_baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sample_tick,
    output logic              bit_tick
);
    logic [PRE_W-1:0]     pre_eff;
    logic [DIV_W-1:0]     div_eff;
    logic [OVS_CNT_W-1:0] ovs_eff;
    logic                 pre_pulse;
    logic                 sample_raw;
    logic                 bit_raw;

    frac_baud_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pre_eff(pre_eff), .div_eff(div_eff),
        .ovs_eff(ovs_eff)
    );

    frac_baud_phase #(.PRE_W(PRE_W), .FRAC(FRAC_BITS)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(wr_en), .pre(pre_eff),
        .pulse(pre_pulse)
    );

    frac_baud_count #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(wr_en), .step(pre_pulse),
        .limit(div_eff), .fire(sample_raw)
    );

    frac_baud_count #(.W(OVS_CNT_W)) u_ovs (
        .clk(clk), .rst_n(rst_n), .clr(wr_en), .step(sample_raw),
        .limit(ovs_eff), .fire(bit_raw)
    );

    // Output gating: quiet during reset and write cycles.
    always_comb begin
        sample_tick = sample_raw && !wr_en && rst_n;
        bit_tick    = bit_raw    && !wr_en && rst_n;
    end
endmodule

// File: rtl/frac_baud_gen_chk.sv
// Assertion checker for frac_baud_gen, attached with bind.
module frac_baud_gen_chk
    import frac_baud_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 sample_tick,
    input logic                 bit_tick,
    input logic                 pre_pulse,
    input logic [PRE_W-1:0]     pre_eff,
    input logic [OVS_CNT_W-1:0] ovs_eff
);
    // R7: a bit strobe always rides on a sample strobe.
    p_bit_on_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);

    // R8: write cycles are quiet.
    p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!sample_tick && !bit_tick));

    // R5: at least four samples per bit, so bit strobes never abut.
    p_bit_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    // R4: the effective prescale never drops below 1.000.
    p_pre_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pre_eff >= PRE_ONE);

    // R3: a prescale of one releases a pulse every clock.
    p_unit_prescale_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_eff == PRE_ONE) |-> pre_pulse);

    // R5: the decoded oversampling count stays within 4..16.
    p_ovs_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovs_eff >= OVS_CNT_W'(4)) && (ovs_eff <= OVS_CNT_W'(16)));
endmodule

bind frac_baud_gen frac_baud_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sample_tick(sample_tick),
    .bit_tick(bit_tick), .pre_pulse(pre_pulse), .pre_eff(pre_eff),
    .ovs_eff(ovs_eff)
);

// File: tb/frac_baud_gen_test.sv
// Bench for frac_baud_gen. It uses a behavioural floor-division model
// compared on every falling clock edge.
module frac_baud_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sample_tick;
    logic       bit_tick;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string req    = "R10";

    // Model state.
    int     m_div, m_pre, m_ovs;
    bit     m_enh, m_pen;
    longint t;

    frac_baud_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    always #2.5 clk = ~clk;

    task automatic model_reset();
        m_div = 1; m_pre = 271; m_ovs = 0; m_enh = 0; m_pen = 0; t = 0;
    endtask

    // Compare outputs with the model, then advance it by one cycle.
    always @(negedge clk) begin
        int     pe, de, ne;
        longint pc, sc;
        bit     es, eb, pp;
        if (!done) begin
            pe = (m_enh && m_pen && m_pre >= 8) ? m_pre : 8;    // R3, R4
            de = (m_div == 0) ? 1 : m_div;                      // R6
            ne = (m_ovs == 0) ? 16 : (m_ovs < 4) ? 4 : m_ovs;   // R5
            pc = (8 * (t + 1)) / pe;                            // R1
            pp = (pc != (8 * t) / pe);
            es = pp && (pc % de == 0);
            sc = pc / de;
            eb = es && (sc % ne == 0);                          // R7
            if (!rst_n || wr_en) begin es = 0; eb = 0; end      // R8, R10
            checks += 2;
            if (sample_tick !== es) begin
                fails++;
                $display("FAIL %s sample_tick t=%0d got %b exp %b", req, t, sample_tick, es);
            end
            if (bit_tick !== eb) begin
                fails++;
                $display("FAIL %s bit_tick t=%0d got %b exp %b", req, t, bit_tick, eb);
            end
            if (!rst_n) model_reset();
            else if (wr_en) begin
                t = 0;
                case (wr_addr)
                    3'd0: m_div = (m_div & 'hFF00) | wr_data;
                    3'd1: m_div = (m_div & 'h00FF) | (int'(wr_data) << 8);
                    3'd2: m_pre = wr_data;                       // R9
                    3'd3: m_pre = (m_pre & 'hFF) | (int'(wr_data[0]) << 8);
                    3'd4: m_ovs = wr_data[3:0];
                    3'd5: begin m_enh = wr_data[0]; m_pen = wr_data[1]; end
                    default: ;
                endcase
            end else t++;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        model_reset();
        req = "R10"; run(4); rst_n = 1'b1;
        req = "R7";  run(40);                      // bypass, D=1: every clock
        req = "R3";  wr(3'd5, 8'h01); run(40);     // enhanced only: still bypassed
        wr(3'd5, 8'h02); run(40);                  // prescaler enable only
        wr(3'd5, 8'h03); run(600);                 // reset value 33.875 applies
        req = "R1";  wr(3'd2, 8'd12); run(120);    // 1.5 fractional
        wr(3'd2, 8'd20); wr(3'd0, 8'd3); run(300); // 2.5 with divisor 3
        req = "R4";  wr(3'd2, 8'd3); wr(3'd0, 8'd1); run(60);
        req = "R9";  wr(3'd3, 8'h01); wr(3'd2, 8'h20); run(200); // cleared: 4.0
        wr(3'd2, 8'h20); wr(3'd3, 8'h01); run(1200);            // 36.0
        req = "R6";  wr(3'd2, 8'd8); wr(3'd0, 8'd0); run(60);
        wr(3'd0, 8'h02); wr(3'd1, 8'h01); wr(3'd4, 8'd4); run(2200);
        req = "R5";  wr(3'd1, 8'd0); wr(3'd0, 8'd1); wr(3'd4, 8'd2); run(40);
        wr(3'd4, 8'd15); run(60);
        wr(3'd4, 8'd0); run(60);
        wr(3'd4, 8'd7); wr(3'd0, 8'd5); run(200);
        req = "R8";  run(13); wr(3'd6, 8'h00); run(100);  // mid-run restart
        req = "R2";  wr(3'd5, 8'h00); run(50);
        req = "R10"; rst_n = 1'b0; run(3); rst_n = 1'b1; run(50);
        finish_up();
    end
endmodule